// File: doc/BRIEF.md
# Last Written Address Tracker

This block remembers where the most recent completed memory write landed. Each write-complete strobe carries a 17-bit byte address. That address is widened to 24 bits and held in a working register. A second, shadow register stands in for the copy that survives power loss. A store pulse commits the working value into the shadow. A recall pulse restores the working value from the shadow. After a power-up recall, the readable value is the restored one until the next write replaces it.

The value is read one byte at a time. A command decoder raises one of three strobes: upper, middle or lower byte. The chosen byte appears on an 8-bit port on the following cycle, together with a valid flag that lasts one cycle. Suppressed or aborted writes never reach this block as a write-complete strobe, so they leave the value alone.

Top module: `last_write_addr_tracker`

## Requirements
- R1: A cycle with `wr_done_i` high and `recall_i` low loads the working value with `wr_addr_i`, zero-extended to 24 bits.
- R2: Without a write strobe or a recall, the working value keeps its contents across any number of cycles, store pulses and byte reads.
- R3: A store pulse copies the working value, as it stood before that clock edge, into the shadow copy. The working value itself does not change.
- R4: A recall pulse loads the working value from the shadow copy. If a write strobe arrives in the same cycle, the recall wins and the write is dropped.
- R5: When a store and a write occur in the same cycle, the shadow receives the previous working value and the working value takes the new address.
- R6: A byte strobe in cycle N drives `rd_data_o` in cycle N+1 with one byte of the working value as it stood before that edge. The upper strobe selects bits 23:16, the middle strobe bits 15:8 and the lower strobe bits 7:0. `rd_valid_o` is high for exactly that one cycle.
- R7: When several byte strobes are high together, the upper strobe takes precedence over the middle, and the middle over the lower.
- R8: In the cycle after a cycle with no byte strobe, `rd_valid_o` is 0 and `rd_data_o` is 0.
- R9: Bits 23:17 of the value always read as zero, so the upper byte never shows more than bit 16 of an address.
- R10: A synchronous reset (`rst_i` high at a clock edge) clears the working copy, the shadow copy, `rd_data_o` and `rd_valid_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_done_i | input | 1 | A memory write completed this cycle |
| wr_addr_i | input | 17 | Address of the completed write |
| store_i | input | 1 | Commit the working value to the shadow copy |
| recall_i | input | 1 | Restore the working value from the shadow copy |
| rd_hi_i | input | 1 | Read strobe for the upper byte |
| rd_mid_i | input | 1 | Read strobe for the middle byte |
| rd_lo_i | input | 1 | Read strobe for the lower byte |
| rd_data_o | output | 8 | Selected byte, registered |
| rd_valid_o | output | 1 | High for the one cycle that carries a read byte |

## Verification
The bench targets same-cycle collisions:
- A recall that coincides with a write. A design that lets the write win would show the new address instead of the restored one.
- A store that coincides with a write. A design that commits the incoming address would restore the wrong value on a later recall.
- A read strobe that coincides with a write. A design that forwards the write would return the new byte one cycle early.

It also sets several read strobes at once, to expose a wrong priority. It writes all-ones addresses, to catch lane mix-ups and bits above 16 that leak into the upper byte. It recalls after reset, to show whether the shadow copy really was cleared.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
  localparam int unsigned LWA_BYTE_W = 8;
  localparam int unsigned LWA_BYTES  = 3;
  localparam int unsigned LWA_W      = LWA_BYTE_W * LWA_BYTES;

  typedef enum logic [1:0] {
    LANE_NONE = 2'd0,
    LANE_HI   = 2'd1,
    LANE_MID  = 2'd2,
    LANE_LO   = 2'd3
  } lane_e;

  // upper strobe outranks middle, middle outranks lower
  function automatic lane_e pick_lane(input logic hi, input logic mid, input logic lo);
    if (hi)       return LANE_HI;
    else if (mid) return LANE_MID;
    else if (lo)  return LANE_LO;
    else          return LANE_NONE;
  endfunction

  // byte number counted from the least significant end
  function automatic logic [LWA_BYTE_W-1:0] lane_byte(input logic [LWA_W-1:0] v,
                                                      input int unsigned idx);
    return v[idx*LWA_BYTE_W +: LWA_BYTE_W];
  endfunction
endpackage

// File: rtl/lwa_capture.sv
module lwa_capture
  import lwa_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_done_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              recall_i,
  input  logic [LWA_W-1:0]  shadow_i,
  output logic [LWA_W-1:0]  work_o
);
  localparam int unsigned PAD_W = LWA_W - ADDR_W;

  logic [LWA_W-1:0] work_q;
  logic [LWA_W-1:0] ext_addr;
  logic             ev_write;
  logic             ev_recall;

  assign ext_addr  = LWA_W'(wr_addr_i);
  assign ev_recall = recall_i;
  assign ev_write  = wr_done_i && !recall_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)          work_q <= '0;
    else if (ev_recall) work_q <= shadow_i;
    else if (ev_write)  work_q <= ext_addr;
  end

  assign work_o = work_q;

  p_reset_clear_r10: assert property (@(posedge clk_i) rst_i |=> work_q == '0);
  p_write_load_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_done_i && !recall_i) |=> work_q[ADDR_W-1:0] == $past(wr_addr_i));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wr_done_i && !recall_i) |=> $stable(work_q));
  p_recall_wins_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    recall_i |=> work_q == $past(shadow_i));

  generate
    if (PAD_W > 0) begin : g_pad
      p_upper_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        work_q[LWA_W-1:ADDR_W] == '0);
    end
  endgenerate
endmodule

// File: rtl/lwa_shadow.sv
module lwa_shadow
  import lwa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             store_i,
  input  logic [LWA_W-1:0] work_i,
  output logic [LWA_W-1:0] shadow_o
);
  logic [LWA_W-1:0] shadow_q;
  logic             ev_commit;

  assign ev_commit = store_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)          shadow_q <= '0;
    else if (ev_commit) shadow_q <= work_i;
  end

  assign shadow_o = shadow_q;

  p_reset_clear_shadow_r10: assert property (@(posedge clk_i) rst_i |=> shadow_q == '0);
  p_commit_old_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    store_i |=> shadow_q == $past(work_i));
  p_shadow_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !store_i |=> $stable(shadow_q));
endmodule

// File: rtl/lwa_readout.sv
module lwa_readout
  import lwa_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  rd_hi_i,
  input  logic                  rd_mid_i,
  input  logic                  rd_lo_i,
  input  logic [LWA_W-1:0]      work_i,
  output logic [LWA_BYTE_W-1:0] rd_data_o,
  output logic                  rd_valid_o
);
  lane_e                 lane;
  logic [LWA_BYTE_W-1:0] lane_val;
  logic                  ev_read;

  assign lane    = pick_lane(rd_hi_i, rd_mid_i, rd_lo_i);
  assign ev_read = (lane != LANE_NONE);

  always_comb begin
    unique case (lane)
      LANE_HI:  lane_val = lane_byte(work_i, LWA_BYTES - 1);
      LANE_MID: lane_val = lane_byte(work_i, 1);
      LANE_LO:  lane_val = lane_byte(work_i, 0);
      default:  lane_val = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_data_o  <= lane_val;
      rd_valid_o <= ev_read;
    end
  end

  p_reset_quiet_r10: assert property (@(posedge clk_i) rst_i |=> (!rd_valid_o && rd_data_o == '0));
  p_one_cycle_valid_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_hi_i || rd_mid_i || rd_lo_i) |=> rd_valid_o);
  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !(rd_hi_i || rd_mid_i || rd_lo_i) |=> (!rd_valid_o && rd_data_o == '0));
  p_hi_first_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_hi_i |=> rd_data_o == $past(work_i[LWA_W-1 -: LWA_BYTE_W]));
  p_low_lane_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_lo_i && !rd_hi_i && !rd_mid_i) |=> rd_data_o == $past(work_i[LWA_BYTE_W-1:0]));
endmodule

// File: rtl/last_write_addr_tracker.sv
module last_write_addr_tracker
  import lwa_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_done_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              store_i,
  input  logic              recall_i,
  input  logic              rd_hi_i,
  input  logic              rd_mid_i,
  input  logic              rd_lo_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o
);
  logic [LWA_W-1:0] work_val;
  logic [LWA_W-1:0] shadow_val;

  lwa_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_done_i (wr_done_i),
    .wr_addr_i (wr_addr_i),
    .recall_i  (recall_i),
    .shadow_i  (shadow_val),
    .work_o    (work_val)
  );

  lwa_shadow u_shadow (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .store_i  (store_i),
    .work_i   (work_val),
    .shadow_o (shadow_val)
  );

  lwa_readout u_readout (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rd_hi_i    (rd_hi_i),
    .rd_mid_i   (rd_mid_i),
    .rd_lo_i    (rd_lo_i),
    .work_i     (work_val),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: tb/tb_last_write_addr_tracker.sv
`timescale 1ns/1ps
module tb_last_write_addr_tracker;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_done;
  logic [16:0] wr_addr;
  logic        store;
  logic        recall;
  logic        rd_hi, rd_mid, rd_lo;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  int unsigned m_work, m_shadow, m_data;
  bit          m_valid;

  always #4 clk = ~clk;

  last_write_addr_tracker dut (
    .clk_i(clk), .rst_i(rst), .wr_done_i(wr_done), .wr_addr_i(wr_addr),
    .store_i(store), .recall_i(recall), .rd_hi_i(rd_hi), .rd_mid_i(rd_mid),
    .rd_lo_i(rd_lo), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  task automatic step(input string tag, input bit r, input bit w, input int unsigned a,
                      input bit st, input bit rc, input bit h, input bit m, input bit l);
    int unsigned old_work;
    rst = r; wr_done = w; wr_addr = a[16:0]; store = st; recall = rc;
    rd_hi = h; rd_mid = m; rd_lo = l;
    @(posedge clk);
    old_work = m_work;
    if (r) begin
      m_work = 0; m_shadow = 0; m_data = 0; m_valid = 0;
    end else begin
      m_valid = h | m | l;
      if (h)      m_data = (old_work / 65536) % 256;
      else if (m) m_data = (old_work / 256) % 256;
      else if (l) m_data = old_work % 256;
      else        m_data = 0;
      if (rc)     m_work = m_shadow;
      else if (w) m_work = a % 131072;
      if (st)     m_shadow = old_work;
    end
    @(negedge clk);
    total++;
    if (rd_data !== m_data[7:0] || rd_valid !== m_valid) begin
      bad++;
      $display("FAIL %s: data=%02h valid=%b expected data=%02h valid=%b",
               tag, rd_data, rd_valid, m_data[7:0], m_valid);
    end
  endtask

  task automatic read_all(input string tag);
    step(tag, 0, 0, 0, 0, 0, 1, 0, 0);
    step(tag, 0, 0, 0, 0, 0, 0, 1, 0);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    rst = 1; wr_done = 0; wr_addr = '0; store = 0; recall = 0;
    rd_hi = 0; rd_mid = 0; rd_lo = 0;
    m_work = 0; m_shadow = 0; m_data = 0; m_valid = 0;
    @(negedge clk);
    step("R10 reset", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R10 reset", 1, 0, 0, 0, 0, 1, 0, 0);
    read_all("R10 cleared value");
    // R1 R6 R9: lane layout of a written address
    step("R1 write", 0, 1, 'h1ABCD, 0, 0, 0, 0, 0);
    read_all("R6 R9 lanes");
    // R8 idle cycles, R2 value held
    for (int i = 0; i < 3; i++) step("R8 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    read_all("R2 held");
    // R6 a read racing a write returns the old byte
    step("R6 read with write", 0, 1, 'h05511, 0, 0, 0, 0, 1);
    step("R6 new byte", 0, 0, 0, 0, 0, 0, 0, 1);
    // R3 store, overwrite, R4 recall
    step("R3 store", 0, 0, 0, 1, 0, 0, 0, 0);
    read_all("R3 work unchanged");
    step("R1 write", 0, 1, 'h00042, 0, 0, 0, 0, 0);
    step("R1 read", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R4 recall", 0, 0, 0, 0, 1, 0, 0, 0);
    read_all("R4 restored");
    // R4 recall beats simultaneous write
    step("R4 recall+write", 0, 1, 'h1FFFF, 0, 1, 0, 0, 0);
    read_all("R4 recall wins");
    // R5 store and write together
    step("R1 write", 0, 1, 'h0A0B0, 0, 0, 0, 0, 0);
    step("R5 store+write", 0, 1, 'h1C3D5, 1, 0, 0, 0, 0);
    read_all("R5 new work");
    step("R5 recall", 0, 0, 0, 0, 1, 0, 0, 0);
    read_all("R5 shadow old");
    // R7 priority with several strobes
    step("R1 write", 0, 1, 'h1FFFF, 0, 0, 0, 0, 0);
    step("R7 hi+mid+lo", 0, 0, 0, 0, 0, 1, 1, 1);
    step("R7 mid+lo", 0, 0, 0, 0, 0, 0, 1, 1);
    step("R7 hi+lo", 0, 0, 0, 0, 0, 1, 0, 1);
    step("R9 upper byte", 0, 0, 0, 0, 0, 1, 0, 0);
    // R10 reset mid-run, shadow cleared
    step("R3 store", 0, 0, 0, 1, 0, 0, 0, 0);
    step("R10 reset", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R10 recall after reset", 0, 0, 0, 0, 1, 0, 0, 0);
    read_all("R10 shadow cleared");
    step("R8 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule